// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block produces the gate pulse train for a flyback converter that switches at a valley of the drain ringing. It takes already-digitized events: a valley strobe from the auxiliary winding, a current-limit trip, and an enable from the supervisor. It also takes the minimum off-time requested by the off-time modulator and a variant select. From these it steps every switching cycle through a fixed order: turn-on, an on-phase whose first cycles are blanked, turn-off, an enforced off-time, a valley search, and a forced restart when no valley arrives.

All durations are parameters counted in cycles of one system clock. The defaults assume 100 MHz. The variant select is captured only while reset is active. It chooses between a low-frequency timing set (value 0) and a high-frequency set (value 1) for three things: the off-time floor, the valley blanking after turn-off, and the restart timeout. A one-cycle strobe marks each turn-off so that an output over-voltage sampler and a fault supervisor can align to it.

Top module: `qr_cycle_seq`

## Requirements
- R1: While reset is active and in the cycle after it, `gate` and `off_strobe` are low and the sequencer is idle.
- R2: When `enable` is high in idle, `gate` goes high at the next clock edge without waiting for a valley.
- R3: After a falling edge of `gate` with `enable` held, `gate` cannot rise before the effective minimum off-time has elapsed. The effective minimum off-time is the larger of `min_off_cyc` and the variant off-time floor.
- R4: A valley is ignored until the arm point, counted in cycles after the fall. The arm point is the larger of the effective minimum off-time and the variant valley blanking time. The first valley sampled at or after the arm point is accepted.
- R5: After an accepted valley sampled at off-cycle index c (0 = first low cycle), `gate` stays low for c+1+ON_DLY_CYC cycles in total and then rises.
- R6: If no valley is accepted, `gate` rises after arm point + timeout + 1 low cycles, where the timeout is the variant value.
- R7: During the first LEB_CYC cycles of a pulse, `trip` is ignored, so a pulse never ends by trip with fewer than LEB_CYC+1 high cycles.
- R8: A `trip` sampled high after the blanking window drives `gate` low at the next clock edge.
- R9: A pulse without trip lasts exactly TON_MAX_CYC cycles.
- R10: `off_strobe` is high for exactly one cycle: the first low cycle after each falling edge of `gate`.
- R11: When `enable` is low, `gate` is low at the next edge and stays low regardless of valley or trip.
- R12: `variant_hf` is sampled only during reset; changing it afterwards does not change any timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also captures `variant_hf` |
| enable | input | 1 | Run permission from the supervisor |
| variant_hf | input | 1 | Timing set select: 0 low-frequency, 1 high-frequency |
| valley | input | 1 | Digitized valley / zero-crossing event |
| trip | input | 1 | Digitized current-limit trip |
| min_off_cyc | input | MIN_OFF_W | Requested minimum off-time in clock cycles |
| gate | output | 1 | Gate drive command |
| off_strobe | output | 1 | One-cycle pulse marking each turn-off |

## Verification
The block is one shared phase counter and a four-state cycle machine, so any internal fault appears in `gate` timing within the switching cycle where it happens. A wrong arm point, timeout sum or delay count changes the number of low cycles between one fall and the next rise. A wrong blanking or cap compare changes the number of high cycles of that same pulse. A lost or extra turn-off transition shows one cycle later as a missing or doubled `off_strobe`. A variant latched at the wrong time changes the gap of the very next cycle.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    localparam int QRS_TW = 20;
    localparam int QRS_CW = QRS_TW + 2;

    typedef logic [QRS_TW-1:0] qrs_dur_t;
    typedef logic [QRS_CW-1:0] qrs_cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_ON    = 2'd2,
        ST_OFF   = 2'd3
    } qrs_state_e;

    typedef struct packed {
        qrs_dur_t off_floor;
        qrs_dur_t ring_blank;
        qrs_dur_t timeout;
    } qrs_var_t;

    function automatic qrs_dur_t qrs_max(qrs_dur_t a, qrs_dur_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic qrs_dur_t qrs_dur(int unsigned v);
        return v[QRS_TW-1:0];
    endfunction

endpackage

// File: rtl/qrs_variant_latch.sv
module qrs_variant_latch
    import qrs_pkg::*;
#(
    parameter int unsigned OFF_FLOOR_LF  = 800,
    parameter int unsigned OFF_FLOOR_HF  = 300,
    parameter int unsigned RING_BLANK_LF = 400,
    parameter int unsigned RING_BLANK_HF = 150,
    parameter int unsigned TIMEOUT_LF    = 900,
    parameter int unsigned TIMEOUT_HF    = 500
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     variant_hf,
    output qrs_var_t timing
);
    localparam qrs_var_t SET_LF = '{off_floor: qrs_dur(OFF_FLOOR_LF),
                                    ring_blank: qrs_dur(RING_BLANK_LF),
                                    timeout: qrs_dur(TIMEOUT_LF)};
    localparam qrs_var_t SET_HF = '{off_floor: qrs_dur(OFF_FLOOR_HF),
                                    ring_blank: qrs_dur(RING_BLANK_HF),
                                    timeout: qrs_dur(TIMEOUT_HF)};

    logic hf_q;

    // Selection is frozen outside reset.
    always_ff @(posedge clk) begin
        if (rst) hf_q <= variant_hf;
    end

    assign timing = hf_q ? SET_HF : SET_LF;
endmodule

// File: rtl/qrs_arm_calc.sv
module qrs_arm_calc
    import qrs_pkg::*;
#(
    parameter int MIN_OFF_W = 16
) (
    input  qrs_var_t               timing,
    input  logic [MIN_OFF_W-1:0]   min_off_cyc,
    output qrs_cnt_t               arm_at,
    output qrs_cnt_t               restart_at
);
    qrs_dur_t req_off;
    qrs_dur_t eff_off;
    qrs_dur_t arm_dur;

    always_comb begin
        req_off    = qrs_dur_t'(min_off_cyc);
        eff_off    = qrs_max(req_off, timing.off_floor);
        arm_dur    = qrs_max(eff_off, timing.ring_blank);
        arm_at     = {2'b00, arm_dur};
        restart_at = {2'b00, arm_dur} + {2'b00, timing.timeout};
    end
endmodule

// File: rtl/qrs_phase_timer.sv
module qrs_phase_timer
    import qrs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    output qrs_cnt_t cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)    cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qr_cycle_seq.sv
module qr_cycle_seq
    import qrs_pkg::*;
#(
    parameter int          MIN_OFF_W     = 16,
    parameter int unsigned LEB_CYC       = 63,
    parameter int unsigned TON_MAX_CYC   = 4500,
    parameter int unsigned ON_DLY_CYC    = 20,
    parameter int unsigned OFF_FLOOR_LF  = 800,
    parameter int unsigned OFF_FLOOR_HF  = 300,
    parameter int unsigned RING_BLANK_LF = 400,
    parameter int unsigned RING_BLANK_HF = 150,
    parameter int unsigned TIMEOUT_LF    = 900,
    parameter int unsigned TIMEOUT_HF    = 500
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 variant_hf,
    input  logic                 valley,
    input  logic                 trip,
    input  logic [MIN_OFF_W-1:0] min_off_cyc,
    output logic                 gate,
    output logic                 off_strobe
);
    localparam qrs_cnt_t LEB_C     = qrs_cnt_t'(LEB_CYC);
    localparam qrs_cnt_t TON_LAST  = qrs_cnt_t'((TON_MAX_CYC > 0) ? TON_MAX_CYC - 1 : 0);
    localparam bit       HAS_DLY   = (ON_DLY_CYC > 0);
    localparam qrs_cnt_t DLY_LAST  = qrs_cnt_t'(HAS_DLY ? ON_DLY_CYC - 1 : 0);

    qrs_state_e state_q, state_d;
    qrs_var_t   timing;
    qrs_cnt_t   cnt, arm_at, restart_at;
    logic       clr;

    qrs_variant_latch #(
        .OFF_FLOOR_LF (OFF_FLOOR_LF),  .OFF_FLOOR_HF (OFF_FLOOR_HF),
        .RING_BLANK_LF(RING_BLANK_LF), .RING_BLANK_HF(RING_BLANK_HF),
        .TIMEOUT_LF   (TIMEOUT_LF),    .TIMEOUT_HF   (TIMEOUT_HF)
    ) var_i (.clk(clk), .rst(rst), .variant_hf(variant_hf), .timing(timing));

    qrs_arm_calc #(.MIN_OFF_W(MIN_OFF_W)) arm_i (
        .timing(timing), .min_off_cyc(min_off_cyc),
        .arm_at(arm_at), .restart_at(restart_at)
    );

    qrs_phase_timer tmr_i (.clk(clk), .rst(rst), .clr(clr), .cnt(cnt));

    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_ON;
                clr     = 1'b1;
            end
            ST_ON: begin
                if ((cnt >= LEB_C && trip) || cnt >= TON_LAST) begin
                    state_d = ST_OFF;
                    clr     = 1'b1;
                end
            end
            ST_OFF: begin
                if (cnt >= arm_at && valley) begin
                    state_d = HAS_DLY ? ST_DELAY : ST_ON;
                    clr     = 1'b1;
                end else if (cnt >= restart_at) begin
                    state_d = ST_ON;
                    clr     = 1'b1;
                end
            end
            ST_DELAY: begin
                if (cnt >= DLY_LAST) begin
                    state_d = ST_ON;
                    clr     = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                clr     = 1'b1;
            end
        endcase
        if (!enable) begin
            state_d = ST_IDLE;
            clr     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            off_strobe <= 1'b0;
        end else begin
            state_q    <= state_d;
            off_strobe <= (state_q == ST_ON) && (state_d != ST_ON);
        end
    end

    assign gate = (state_q == ST_ON);
endmodule

// File: rtl/qrs_checker.sv
module qrs_checker #(
    parameter int unsigned LEB_CYC      = 63,
    parameter int unsigned TON_MAX_CYC  = 4500,
    parameter int unsigned OFF_FLOOR_LF = 800,
    parameter int unsigned OFF_FLOOR_HF = 300
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic variant_hf,
    input logic gate,
    input logic off_strobe
);
    logic [31:0] high_cnt, low_cnt;
    logic        hf_q, run_q;
    logic [31:0] floor_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= '0;
            low_cnt  <= '0;
            run_q    <= 1'b0;
            hf_q     <= variant_hf;
        end else begin
            high_cnt <= gate ? high_cnt + 1 : '0;
            low_cnt  <= gate ? '0 : ((low_cnt != '1) ? low_cnt + 1 : low_cnt);
            if (!enable)   run_q <= 1'b0;
            else if (gate) run_q <= 1'b1;
        end
    end

    assign floor_c = hf_q ? OFF_FLOOR_HF : OFF_FLOOR_LF;

    assert_gate_off_when_disabled_R11: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !gate);

    assert_strobe_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(gate) |-> off_strobe);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
        off_strobe |-> !gate ##1 !off_strobe);

    assert_on_cap_R9: assert property (@(posedge clk) disable iff (rst)
        gate |-> high_cnt < TON_MAX_CYC);

    assert_blank_kept_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate) && $past(enable)) |-> high_cnt >= LEB_CYC + 1);

    assert_min_off_kept_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate) && run_q) |-> low_cnt >= floor_c + 1);
endmodule

bind qr_cycle_seq qrs_checker #(
    .LEB_CYC(LEB_CYC), .TON_MAX_CYC(TON_MAX_CYC),
    .OFF_FLOOR_LF(OFF_FLOOR_LF), .OFF_FLOOR_HF(OFF_FLOOR_HF)
) chk_i (
    .clk(clk), .rst(rst), .enable(enable), .variant_hf(variant_hf),
    .gate(gate), .off_strobe(off_strobe)
);

// File: tb/qr_cycle_seq_tb_top.sv
module qr_cycle_seq_tb_top;
    localparam int LEB = 5, TON = 40, DLY = 3;
    localparam int FL_LF = 20, FL_HF = 10, RB_LF = 12, RB_HF = 14, TO_LF = 15, TO_HF = 8;

    logic clk = 1'b0, rst = 1'b1, enable = 1'b0, variant_hf = 1'b0;
    logic valley = 1'b0, trip = 1'b0;
    logic [15:0] min_off_cyc = '0;
    logic gate, off_strobe;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    qr_cycle_seq #(
        .MIN_OFF_W(16), .LEB_CYC(LEB), .TON_MAX_CYC(TON), .ON_DLY_CYC(DLY),
        .OFF_FLOOR_LF(FL_LF), .OFF_FLOOR_HF(FL_HF),
        .RING_BLANK_LF(RB_LF), .RING_BLANK_HF(RB_HF),
        .TIMEOUT_LF(TO_LF), .TIMEOUT_HF(TO_HF)
    ) dut_i (.*);

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(bit hf);
        rst = 1'b1; enable = 1'b0; variant_hf = hf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Measures one full pulse and the low gap after it (samples at negedge).
    task automatic measure(output int h, output int l);
        @(negedge clk);
        while (gate !== 1'b0) @(negedge clk);
        while (gate !== 1'b1) @(negedge clk);
        h = 0;
        while (gate === 1'b1) begin h++; @(negedge clk); end
        check(off_strobe === 1'b1, "R10 strobe at fall", int'(off_strobe), 1);
        l = 0;
        while (gate === 1'b0) begin
            l++;
            @(negedge clk);
            if (l == 1) check(off_strobe === 1'b0, "R10 strobe width", int'(off_strobe), 0);
        end
    endtask

    task automatic expect_cycle(string req, int eh, int el);
        int h, l;
        measure(h, l);
        measure(h, l);
        if (eh >= 0) check(h == eh, req, h, eh);
        if (el >= 0) check(l == el, req, l, el);
    endtask

    task automatic t_reset_and_start;
        do_reset(1'b0);
        check(gate === 1'b0 && off_strobe === 1'b0, "R1 reset state", int'({gate, off_strobe}), 0);
        valley = 1'b1; trip = 1'b1; min_off_cyc = '0;
        @(negedge clk);
        check(gate === 1'b0, "R1 idle without enable", int'(gate), 0);
        enable = 1'b1;
        @(negedge clk);
        check(gate === 1'b1, "R2 first pulse without valley", int'(gate), 1);
    endtask

    task automatic t_lf_cycles;
        expect_cycle("R7 R4 R5 blanked trip, first armed valley", LEB + 1, RB_LF > FL_LF ? RB_LF + 1 + DLY : FL_LF + 1 + DLY);
        min_off_cyc = 16'd30;
        expect_cycle("R3 requested min off above floor", LEB + 1, 30 + 1 + DLY);
        min_off_cyc = 16'd0; valley = 1'b0;
        expect_cycle("R6 timeout restart", LEB + 1, FL_LF + TO_LF + 1);
        trip = 1'b0; valley = 1'b1;
        expect_cycle("R9 on-time cap", TON, -1);
    endtask

    task automatic t_trip_after_blank;
        @(negedge clk);
        while (gate !== 1'b0) @(negedge clk);
        while (gate !== 1'b1) @(negedge clk);
        repeat (9) @(negedge clk);
        check(gate === 1'b1, "R8 still on before trip", int'(gate), 1);
        trip = 1'b1;
        @(negedge clk);
        check(gate === 1'b0, "R8 trip ends pulse at next edge", int'(gate), 0);
        trip = 1'b0;
    endtask

    task automatic t_disable;
        while (gate !== 1'b1) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(gate === 1'b0, "R11 gate low after disable", int'(gate), 0);
        check(off_strobe === 1'b1, "R10 strobe on disable fall", int'(off_strobe), 1);
        valley = 1'b1; trip = 1'b0;
        begin
            int highs = 0;
            repeat (60) begin @(negedge clk); if (gate !== 1'b0) highs++; end
            check(highs == 0, "R11 stays low while disabled", highs, 0);
        end
    endtask

    task automatic t_hf_variant;
        do_reset(1'b1);
        valley = 1'b1; trip = 1'b1; min_off_cyc = '0;
        enable = 1'b1;
        expect_cycle("R4 HF valley blank above floor", LEB + 1, RB_HF + 1 + DLY);
        valley = 1'b0;
        expect_cycle("R6 HF timeout restart", LEB + 1, RB_HF + TO_HF + 1);
        variant_hf = 1'b0; valley = 1'b1;
        expect_cycle("R12 variant change after reset ignored", LEB + 1, RB_HF + 1 + DLY);
        min_off_cyc = 16'd20;
        expect_cycle("R3 HF requested min off", LEB + 1, 20 + 1 + DLY);
    endtask

    initial begin
        t_reset_and_start;
        t_lf_cycles;
        t_trip_after_blank;
        t_disable;
        t_hf_variant;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule